// File: doc/BRIEF.md
# Thermal Trip and Clock-Throttle Controller

This block keeps a core inside its thermal budget. It watches a stream of digital temperature readings, each marked by a valid strobe. It keeps a performance level between zero and one full duty period. Whenever it throttles, it stalls the core clock for part of every period. A trip path in hardware starts throttling without any help from software. A second, higher level raises a shutdown request that stays on until the next reset.

On every valid reading the performance level moves by a proportional-plus-derivative step. One coefficient weights the change since the last reading. The other weights the distance from the target temperature. The result is then clamped to the legal range. Software can force throttling at any time. The hardware trip level does the same on its own, and it responds faster than a software loop could.

Top module: `thermal_throttle_ctrl`

## Requirements
- R1: After a synchronous reset the block drives clk_en_o = 1, duty_o = PERIOD, throttle_o = 0 and shutdown_o = 0.
- R2: While throttle_o is 0, clk_en_o is 1 on every cycle, one cycle after the throttle state is sampled.
- R3: On each valid reading the new level is clamp(duty − (coef_slope·(T − Tprev) + coef_error·(T − target)), 0, PERIOD). Both coefficients are two's-complement signed and temperatures are unsigned. The new level appears on duty_o one cycle after the strobe. Without a strobe, duty_o holds.
- R4: While throttled, a free-running phase counter steps from 0 to PERIOD−1 and wraps. clk_en_o is high only at phases below the level, so any PERIOD consecutive throttled cycles with a steady level contain exactly duty_o enable cycles.
- R5: A valid reading at or above THROTTLE_TEMP sets the hardware trip. A valid reading below it clears the trip. throttle_o equals sw_throttle_i OR the trip, registered one cycle later.
- R6: A valid reading at or above CRIT_TEMP sets shutdown_o on the next cycle. It then stays set until reset, whatever readings follow.
- R7: The previous-temperature register loads only on a valid strobe. For the first reading after reset, the reading serves as its own previous value, so the slope term is zero. Input changes made without a strobe leave duty_o and throttle_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_valid_i | input | 1 | Temperature reading strobe |
| sample_temp_i | input | TEMP_W | Unsigned temperature reading |
| target_temp_i | input | TEMP_W | Unsigned target temperature |
| coef_slope_i | input | COEF_W | Signed weight of the temperature change |
| coef_error_i | input | COEF_W | Signed weight of the distance to target |
| sw_throttle_i | input | 1 | Software throttle request |
| clk_en_o | output | 1 | Clock-enable gating pattern |
| duty_o | output | $clog2(PERIOD+1) | Current performance level |
| throttle_o | output | 1 | Throttling active |
| shutdown_o | output | 1 | Latched shutdown request |

## Verification
The bench builds the block with PERIOD = 20, THROTTLE_TEMP = 80, CRIT_TEMP = 100, 8-bit temperatures and 8-bit coefficients. The short period lets a full gating window be counted in twenty cycles, so many windows fit into one run. Small coefficient steps are enough to reach both clamp limits. Readings between 30 and 110 cross both trip levels in either direction.

// File: rtl/thermal_pkg.sv
package thermal_pkg;
  typedef enum logic {
    MODE_FULL  = 1'b0,
    MODE_GATED = 1'b1
  } run_mode_e;
endpackage

// File: rtl/thr_trip_detect.sv
module thr_trip_detect #(
  parameter int TEMP_W        = 8,
  parameter int THROTTLE_TEMP = 85,
  parameter int CRIT_TEMP     = 105
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid_i,
  input  logic [TEMP_W-1:0] temp_i,
  input  logic              sw_req_i,
  output logic              throttle_o,
  output logic              shutdown_o
);
  localparam logic [TEMP_W-1:0] THR_L  = TEMP_W'(THROTTLE_TEMP);
  localparam logic [TEMP_W-1:0] CRIT_L = TEMP_W'(CRIT_TEMP);

  logic trip_q, trip_d, throttle_q, shutdown_q;

  always_comb begin
    trip_d = trip_q;
    if (valid_i) trip_d = (temp_i >= THR_L);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trip_q     <= 1'b0;
      throttle_q <= 1'b0;
      shutdown_q <= 1'b0;
    end else begin
      trip_q     <= trip_d;
      throttle_q <= sw_req_i | trip_d;
      if (valid_i && temp_i >= CRIT_L) shutdown_q <= 1'b1;
    end
  end

  assign throttle_o = throttle_q;
  assign shutdown_o = shutdown_q;

  AST_SHUTDOWN_HOLD: assert property (@(posedge clk) disable iff (rst)
    shutdown_q |=> shutdown_q); // R6
  AST_CRIT_SETS: assert property (@(posedge clk) disable iff (rst)
    (valid_i && temp_i >= CRIT_L) |=> shutdown_q); // R6
  AST_SW_FORCES: assert property (@(posedge clk) disable iff (rst)
    sw_req_i |=> throttle_q); // R5
endmodule

// File: rtl/thr_duty_calc.sv
module thr_duty_calc #(
  parameter int TEMP_W = 8,
  parameter int COEF_W = 8,
  parameter int PERIOD = 100,
  localparam int DUTY_W = $clog2(PERIOD + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     valid_i,
  input  logic        [TEMP_W-1:0] temp_i,
  input  logic        [TEMP_W-1:0] target_i,
  input  logic signed [COEF_W-1:0] coef_slope_i,
  input  logic signed [COEF_W-1:0] coef_error_i,
  output logic        [DUTY_W-1:0] duty_o
);
  localparam int DIFF_W = TEMP_W + 1;
  localparam int SUM_W  = COEF_W + DIFF_W + 3;
  localparam logic signed [SUM_W-1:0] MAX_S = SUM_W'(PERIOD);

  logic [TEMP_W-1:0] prev_q;
  logic              seen_q;
  logic [DUTY_W-1:0] duty_q;

  logic        [TEMP_W-1:0] prev_eff;
  logic signed [DIFF_W-1:0] slope, err;
  logic signed [SUM_W-1:0]  delta, cand;
  logic        [DUTY_W-1:0] duty_next;

  always_comb begin
    prev_eff  = seen_q ? prev_q : temp_i;
    slope     = $signed({1'b0, temp_i}) - $signed({1'b0, prev_eff});
    err       = $signed({1'b0, temp_i}) - $signed({1'b0, target_i});
    delta     = SUM_W'(coef_slope_i) * SUM_W'(slope)
              + SUM_W'(coef_error_i) * SUM_W'(err);
    cand      = $signed({{(SUM_W-DUTY_W){1'b0}}, duty_q}) - delta;
    if (cand < 0)          duty_next = '0;
    else if (cand > MAX_S) duty_next = DUTY_W'(PERIOD);
    else                   duty_next = cand[DUTY_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      seen_q <= 1'b0;
      duty_q <= DUTY_W'(PERIOD);
    end else if (valid_i) begin
      prev_q <= temp_i;
      seen_q <= 1'b1;
      duty_q <= duty_next;
    end
  end

  assign duty_o = duty_q;

  AST_DUTY_BOUND: assert property (@(posedge clk) disable iff (rst)
    duty_q <= DUTY_W'(PERIOD)); // R3
  AST_DUTY_HOLD: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> $stable(duty_q)); // R3
  AST_PREV_HOLD: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> $stable(prev_q)); // R7
endmodule

// File: rtl/thr_gate_pattern.sv
module thr_gate_pattern
  import thermal_pkg::*;
#(
  parameter int PERIOD = 100,
  localparam int DUTY_W = $clog2(PERIOD + 1),
  localparam int PH_W   = $clog2(PERIOD)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              throttle_i,
  input  logic [DUTY_W-1:0] duty_i,
  output logic              clk_en_o
);
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(PERIOD - 1);

  logic [PH_W-1:0] phase_q;
  logic            en_q;
  run_mode_e       mode;

  assign mode = throttle_i ? MODE_GATED : MODE_FULL;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      en_q    <= 1'b1;
    end else begin
      phase_q <= (phase_q == LAST_PH) ? '0 : phase_q + 1'b1;
      en_q    <= (mode == MODE_FULL) || (DUTY_W'(phase_q) < duty_i);
    end
  end

  assign clk_en_o = en_q;

  AST_FULL_RUN: assert property (@(posedge clk) disable iff (rst)
    !throttle_i |=> en_q); // R2
  AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (rst)
    (phase_q == LAST_PH) |=> (phase_q == '0)); // R4
  AST_ZERO_DUTY: assert property (@(posedge clk) disable iff (rst)
    (throttle_i && duty_i == '0) |=> !en_q); // R4
endmodule

// File: rtl/thermal_throttle_ctrl.sv
module thermal_throttle_ctrl #(
  parameter int TEMP_W        = 8,
  parameter int COEF_W        = 8,
  parameter int PERIOD        = 100,
  parameter int THROTTLE_TEMP = 85,
  parameter int CRIT_TEMP     = 105,
  localparam int DUTY_W = $clog2(PERIOD + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     sample_valid_i,
  input  logic        [TEMP_W-1:0] sample_temp_i,
  input  logic        [TEMP_W-1:0] target_temp_i,
  input  logic signed [COEF_W-1:0] coef_slope_i,
  input  logic signed [COEF_W-1:0] coef_error_i,
  input  logic                     sw_throttle_i,
  output logic                     clk_en_o,
  output logic        [DUTY_W-1:0] duty_o,
  output logic                     throttle_o,
  output logic                     shutdown_o
);
  logic [DUTY_W-1:0] duty_w;
  logic              throttle_w;

  thr_trip_detect #(
    .TEMP_W(TEMP_W), .THROTTLE_TEMP(THROTTLE_TEMP), .CRIT_TEMP(CRIT_TEMP)
  ) u_trip (
    .clk(clk), .rst(rst), .valid_i(sample_valid_i), .temp_i(sample_temp_i),
    .sw_req_i(sw_throttle_i), .throttle_o(throttle_w), .shutdown_o(shutdown_o)
  );

  thr_duty_calc #(
    .TEMP_W(TEMP_W), .COEF_W(COEF_W), .PERIOD(PERIOD)
  ) u_duty (
    .clk(clk), .rst(rst), .valid_i(sample_valid_i), .temp_i(sample_temp_i),
    .target_i(target_temp_i), .coef_slope_i(coef_slope_i),
    .coef_error_i(coef_error_i), .duty_o(duty_w)
  );

  thr_gate_pattern #(
    .PERIOD(PERIOD)
  ) u_gate (
    .clk(clk), .rst(rst), .throttle_i(throttle_w), .duty_i(duty_w),
    .clk_en_o(clk_en_o)
  );

  assign duty_o     = duty_w;
  assign throttle_o = throttle_w;
endmodule

// File: tb/thermal_throttle_ctrl_test.sv
module thermal_throttle_ctrl_test;
  localparam int TW = 8, CW = 8, PER = 20, THR = 80, CRIT = 100;
  localparam int DW = $clog2(PER + 1);

  logic clk = 1'b0, rst = 1'b1;
  logic valid = 1'b0, sw = 1'b0;
  logic [TW-1:0] temp = '0, tgt = 8'd50;
  logic signed [CW-1:0] c1 = '0, c2 = '0;
  logic en, thr_o, sd;
  logic [DW-1:0] duty;

  int checks = 0, fails = 0, cyc = 0;
  int m_duty, m_prev, m_have, m_trip, m_sd, m_thr, m_en, m_phase;

  always #2 clk = ~clk;

  thermal_throttle_ctrl #(
    .TEMP_W(TW), .COEF_W(CW), .PERIOD(PER), .THROTTLE_TEMP(THR), .CRIT_TEMP(CRIT)
  ) uut (
    .clk(clk), .rst(rst), .sample_valid_i(valid), .sample_temp_i(temp),
    .target_temp_i(tgt), .coef_slope_i(c1), .coef_error_i(c2),
    .sw_throttle_i(sw), .clk_en_o(en), .duty_o(duty), .throttle_o(thr_o),
    .shutdown_o(sd)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Behavioural reference, advanced at each rising edge
  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_duty = PER; m_prev = 0; m_have = 0; m_trip = 0;
      m_sd = 0; m_thr = 0; m_en = 1; m_phase = 0;
    end else begin
      int nt, pv, d, nd;
      nt = valid ? int'(temp >= THR) : m_trip;
      m_en = (!m_thr || m_phase < m_duty) ? 1 : 0;
      m_phase = (m_phase + 1) % PER;
      m_thr = (sw || nt) ? 1 : 0;
      m_trip = nt;
      if (valid) begin
        pv = m_have ? m_prev : int'(temp);
        d = int'(c1) * (int'(temp) - pv) + int'(c2) * (int'(temp) - int'(tgt));
        nd = m_duty - d;
        m_duty = nd < 0 ? 0 : (nd > PER ? PER : nd);
        m_prev = int'(temp); m_have = 1;
        if (temp >= CRIT) m_sd = 1;
      end
    end
  end

  // Per-cycle comparison against the reference
  always @(negedge clk) begin
    if (!rst && cyc > 0) begin
      check(en == m_en, m_thr ? "R4 clk_en" : "R2 clk_en", en, m_en);
      check(duty == m_duty, "R3 duty", duty, m_duty);
      check(thr_o == m_thr, "R5 throttle", thr_o, m_thr);
      check(sd == m_sd, "R6 shutdown", sd, m_sd);
    end
  end

  task automatic sample(input int t);
    @(negedge clk); temp = TW'(t); valid = 1'b1;
    @(negedge clk); valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    int cnt, d0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(en == 1 && duty == PER && !thr_o && !sd, "R1 reset", {en, thr_o, sd}, 3'b100);
    repeat (30) @(negedge clk);                     // R2 idle full run
    c1 = 8'sd5; c2 = 8'sd1;
    sample(50);
    check(duty == PER, "R7 first sample zero slope", duty, PER);
    sample(52);
    check(duty == 8, "R3 update 20-12", duty, 8);
    sw = 1'b1;
    repeat (3) @(negedge clk);
    cnt = 0;
    for (int i = 0; i < PER; i++) begin cnt += en; @(negedge clk); end
    check(cnt == 8, "R4 enables per window", cnt, 8);
    c1 = -8'sd3;
    sample(40);
    check(duty == 0, "R3 clamp low", duty, 0);
    cnt = 0;
    for (int i = 0; i < PER; i++) begin @(negedge clk); cnt += en; end
    check(cnt == 0, "R4 zero duty stalls", cnt, 0);
    c1 = 8'sd1;
    sample(20);
    check(duty == PER, "R3 clamp high", duty, PER);
    sw = 1'b0;
    d0 = duty;
    temp = 8'd99; c1 = 8'sd7;
    repeat (10) @(negedge clk);
    check(duty == d0 && !thr_o, "R7 no strobe ignored", duty, d0);
    c1 = 8'sd0; c2 = 8'sd0;
    sample(85);
    check(thr_o == 1, "R5 hw trip", thr_o, 1);
    sample(60);
    check(thr_o == 0, "R5 trip clears", thr_o, 0);
    sample(100);
    check(sd == 1, "R6 critical", sd, 1);
    sample(30);
    repeat (5) @(negedge clk);
    check(sd == 1, "R6 latched", sd, 1);
    rst = 1'b1; @(negedge clk); rst = 1'b0; @(negedge clk);
    check(en == 1 && duty == PER && !thr_o && !sd, "R1 reset again", {en, thr_o, sd}, 3'b100);
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      valid = ($urandom_range(0, 2) == 0);
      temp  = TW'($urandom_range(30, 110));
      c1    = CW'($urandom_range(0, 8)) - 8'sd4;
      c2    = CW'($urandom_range(0, 8)) - 8'sd4;
      if ($urandom_range(0, 15) == 0) sw = ~sw;
    end
    valid = 1'b0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule